// File: doc/BRIEF.md
# Two-way write-back cache controller

The block is a two-way set-associative cache controller with one-word lines, placed between a CPU request port and a word-wide main-memory port. The CPU raises a request with an address, a read/write flag and write data, and holds them steady until the controller raises ready. Lookups that hit complete in the cycle they are presented. A miss runs a short sequence against memory, using a request/acknowledge handshake for every transfer: an optional write-back of a dirty victim, then a fetch for reads.

Each line has its own tag, valid bit and dirty bit. Each set has a single bit naming its most recently used way, and that bit decides the victim once both ways are valid. A flush input drops every line at once. The dirty contents of dropped lines are discarded, not written back.

Top module: `wb2_cache`

## Requirements
- R1: After reset every line is invalid, ready and the memory request are low, and the first access to any address misses.
- R2: A lookup hits only when one way of the indexed set holds a matching tag with its valid bit set. A hit raises ready in the same cycle as the request, returns the cached word on reads, and causes no memory transfer.
- R3: A write hit replaces the cached word and marks that line dirty. It issues no memory write.
- R4: A read miss fetches exactly one word from memory at the request address. It installs the tag and the word with the dirty bit clear, and returns that word.
- R5: A write miss makes no fetch. It installs the new tag and the write data and marks the line dirty.
- R6: On a miss, the victim is written to memory at the address formed from its stored tag and the set index, only when it is both valid and dirty. The write happens before any fetch, and the data written is the victim's cached word.
- R7: On a miss, way 0 is filled if it is invalid, otherwise way 1 if it is invalid. When both ways are valid, the victim is the way that was not most recently accessed. Hits and fills both mark the accessed way as most recently used.
- R8: A one-cycle flush pulse, given while no access is in progress, clears every valid and dirty bit without writing anything back. Later accesses miss.
- R9: Ready stays low through every write-back and fetch. A memory request keeps its address and direction until acknowledged. Ready and the memory request are never high together.
- R10: The set index is the low log2(SETS) bits of the word address and the tag is the remaining upper bits. Addresses in different sets never displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all lines (sampled while idle) |
| cpu_req_i | input | 1 | CPU access request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | Word address |
| cpu_wdata_i | input | DW | Write data |
| cpu_rdata_o | output | DW | Read data, valid while ready is high |
| cpu_ready_o | output | 1 | Access completes this cycle |
| mem_req_o | output | 1 | Memory transfer request, held until acknowledge |
| mem_we_o | output | 1 | 1 = memory write (write-back), 0 = fetch |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write-back data |
| mem_rdata_i | input | DW | Fetched data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory transfer done |

## Verification
Several kinds of internal fault show up at the ports within one access. A wrong valid bit or tag shows as a hit/miss error: ready arrives at the wrong time, or memory traffic appears where none is due. A lost dirty bit or a wrong replacement bit stays hidden until that set next evicts. Then the write-back is missing, lands at the wrong address, or carries stale data, and a later read returns the wrong word. The bench keeps its own model of tags, valid and dirty bits, replacement bits and memory contents. It predicts the latency class, the write-back count, address and data, and the fetch count and read data of every access, so such faults are caught at the first eviction that exposes them.

// File: rtl/wb2_pkg.sv
package wb2_pkg;
  localparam int WAYS = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_WBACK, ST_FILL, ST_RESP} st_e;
endpackage

// File: rtl/wb2_lookup.sv
module wb2_lookup #(
  parameter int TW = 5
) (
  input  logic [TW-1:0] tag_i,
  input  logic [TW-1:0] way_tag_i [wb2_pkg::WAYS],
  input  logic [wb2_pkg::WAYS-1:0] way_valid_i,
  input  logic          mru_i,
  output logic          hit_o,
  output logic          hit_way_o,
  output logic          victim_way_o
);
  logic [wb2_pkg::WAYS-1:0] match;

  for (genvar w = 0; w < wb2_pkg::WAYS; w++) begin : g_cmp
    assign match[w] = way_valid_i[w] && (way_tag_i[w] == tag_i);
  end

  assign hit_o     = |match;
  assign hit_way_o = match[1];

  // invalid ways first, else the way not most recently used
  always_comb begin
    if (!way_valid_i[0])      victim_way_o = 1'b0;
    else if (!way_valid_i[1]) victim_way_o = 1'b1;
    else                      victim_way_o = ~mru_i;
  end

  // R2
  always_comb begin
    hit_onehot_chk: assert ($onehot0(match) || $isunknown(match));
  end
endmodule

// File: rtl/wb2_store.sv
module wb2_store #(
  parameter int SETS = 8,
  parameter int TW   = 5,
  parameter int DW   = 16,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [IW-1:0] idx_i,
  output logic [TW-1:0] rd_tag_o   [wb2_pkg::WAYS],
  output logic [DW-1:0] rd_data_o  [wb2_pkg::WAYS],
  output logic [wb2_pkg::WAYS-1:0] rd_valid_o,
  output logic [wb2_pkg::WAYS-1:0] rd_dirty_o,
  output logic          rd_mru_o,
  input  logic          wr_en_i,
  input  logic          wr_way_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_dirty_i,
  input  logic          mru_en_i,
  input  logic          mru_way_i
);
  logic [TW-1:0] tag_q   [SETS][wb2_pkg::WAYS];
  logic [DW-1:0] data_q  [SETS][wb2_pkg::WAYS];
  logic [wb2_pkg::WAYS-1:0] valid_q [SETS];
  logic [wb2_pkg::WAYS-1:0] dirty_q [SETS];
  logic [SETS-1:0] mru_q;

  for (genvar w = 0; w < wb2_pkg::WAYS; w++) begin : g_rd
    assign rd_tag_o[w]  = tag_q[idx_i][w];
    assign rd_data_o[w] = data_q[idx_i][w];
  end
  assign rd_valid_o = valid_q[idx_i];
  assign rd_dirty_o = dirty_q[idx_i];
  assign rd_mru_o   = mru_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < wb2_pkg::WAYS; w++) begin
          tag_q[s][w]  <= '0;
          data_q[s][w] <= '0;
        end
      end
      mru_q <= '0;
    end else if (flush_i) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        tag_q[idx_i][wr_way_i]   <= wr_tag_i;
        data_q[idx_i][wr_way_i]  <= wr_data_i;
        valid_q[idx_i][wr_way_i] <= 1'b1;
        dirty_q[idx_i][wr_way_i] <= wr_dirty_i;
      end
      if (mru_en_i) mru_q[idx_i] <= mru_way_i;
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    // R3
    dirty_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dirty_q[s] & ~valid_q[s]) == '0);
    // R8
    flush_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (valid_q[s] == '0) && (dirty_q[s] == '0));
  end
endmodule

// File: rtl/wb2_cache.sv
module wb2_cache
  import wb2_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int SETS = 8,
  localparam int IW  = $clog2(SETS),
  localparam int TW  = AW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          cpu_req_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  st_e st_q, st_d;
  logic vway_q, vway_d;

  logic [IW-1:0] idx;
  logic [TW-1:0] tag;
  assign idx = cpu_addr_i[IW-1:0];
  assign tag = cpu_addr_i[AW-1:IW];

  logic [TW-1:0] rd_tag  [WAYS];
  logic [DW-1:0] rd_data [WAYS];
  logic [WAYS-1:0] rd_valid, rd_dirty;
  logic rd_mru, hit, hit_way, victim_way;

  logic          wr_en, wr_way, wr_dirty, mru_en, mru_way, flush_en;
  logic [DW-1:0] wr_data;

  wb2_lookup #(.TW(TW)) u_lookup (
    .tag_i(tag), .way_tag_i(rd_tag), .way_valid_i(rd_valid), .mru_i(rd_mru),
    .hit_o(hit), .hit_way_o(hit_way), .victim_way_o(victim_way)
  );

  wb2_store #(.SETS(SETS), .TW(TW), .DW(DW)) u_store (
    .clk_i, .rst_ni, .flush_i(flush_en), .idx_i(idx),
    .rd_tag_o(rd_tag), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rd_dirty_o(rd_dirty), .rd_mru_o(rd_mru),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_tag_i(tag), .wr_data_i(wr_data),
    .wr_dirty_i(wr_dirty), .mru_en_i(mru_en), .mru_way_i(mru_way)
  );

  logic idle_acc;
  assign idle_acc = (st_q == ST_IDLE) && cpu_req_i && !flush_i;
  assign flush_en = (st_q == ST_IDLE) && flush_i;

  always_comb begin
    st_d     = st_q;
    vway_d   = vway_q;
    wr_en    = 1'b0;
    wr_way   = vway_q;
    wr_data  = cpu_wdata_i;
    wr_dirty = 1'b1;
    mru_en   = 1'b0;
    mru_way  = vway_q;
    unique case (st_q)
      ST_IDLE: if (idle_acc) begin
        if (hit) begin
          wr_en   = cpu_we_i;
          wr_way  = hit_way;
          mru_en  = 1'b1;
          mru_way = hit_way;
        end else begin
          vway_d = victim_way;
          if (rd_valid[victim_way] && rd_dirty[victim_way]) st_d = ST_WBACK;
          else if (cpu_we_i)                                 st_d = ST_RESP;
          else                                               st_d = ST_FILL;
        end
      end
      ST_WBACK: if (mem_ack_i) st_d = cpu_we_i ? ST_RESP : ST_FILL;
      ST_FILL: if (mem_ack_i) begin
        wr_en    = 1'b1;
        wr_data  = mem_rdata_i;
        wr_dirty = 1'b0;
        st_d     = ST_RESP;
      end
      ST_RESP: begin
        wr_en  = cpu_we_i;
        mru_en = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      vway_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      vway_q <= vway_d;
    end
  end

  assign cpu_ready_o = (idle_acc && hit) || (st_q == ST_RESP);
  assign cpu_rdata_o = (st_q == ST_RESP) ? rd_data[vway_q] : rd_data[hit_way];
  assign mem_req_o   = (st_q == ST_WBACK) || (st_q == ST_FILL);
  assign mem_we_o    = (st_q == ST_WBACK);
  assign mem_addr_o  = (st_q == ST_WBACK) ? {rd_tag[vway_q], idx} : cpu_addr_i;
  assign mem_wdata_o = rd_data[vway_q];

  // R9
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R9
  rdy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_ready_o && mem_req_o));
  // R6
  wb_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> rd_valid[vway_q] && rd_dirty[vway_q]);
  // R2
  hit_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && cpu_ready_o |=> !mem_req_o);
endmodule

// File: tb/wb2_cache_test.sv
`timescale 1ns/1ps
module wb2_cache_test;
  localparam int AW = 8, DW = 16, SETS = 8;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, mem_wdata, mem_rdata = '0;
  logic cpu_ready, mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  wb2_cache #(.AW(AW), .DW(DW), .SETS(SETS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] mem_b [256];
  logic [DW-1:0] truth [256];
  logic [4:0] m_tag [SETS][2];
  bit m_val [SETS][2];
  bit m_dirty [SETS][2];
  bit m_mru [SETS];
  int wb_cnt = 0, fill_cnt = 0, last_waits = 0;
  logic [AW-1:0] last_wb_addr;
  logic [DW-1:0] last_wb_data;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory responder, 0..2 cycles of extra latency
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (mem_we) begin
          mem_b[mem_addr] = mem_wdata;
          last_wb_addr = mem_addr;
          last_wb_data = mem_wdata;
          wb_cnt++;
        end else begin
          mem_rdata = mem_b[mem_addr];
          fill_cnt++;
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  task automatic do_access(input bit we, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input string rq);
    int i = int'(a[2:0]);
    logic [4:0] t = a[7:3];
    int h = -1, w, wb0, f0, waits;
    bit ewb, efill;
    logic [AW-1:0] wba;
    logic [DW-1:0] rd;
    for (int k = 0; k < 2; k++) if (m_val[i][k] && m_tag[i][k] == t) h = k;
    if (h >= 0) begin
      w = h; ewb = 0; efill = 0;
    end else begin
      w = !m_val[i][0] ? 0 : (!m_val[i][1] ? 1 : int'(!m_mru[i]));
      ewb = m_val[i][w] && m_dirty[i][w];
      efill = !we;
    end
    wba = {m_tag[i][w], a[2:0]};
    wb0 = wb_cnt; f0 = fill_cnt;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    waits = 0;
    #1;
    while (!cpu_ready) begin
      @(negedge clk); #1; waits++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    last_waits = waits;
    if (h >= 0) chk(waits == 0, "R2 hit same-cycle ready", waits, 0);
    else        chk(waits > 0, "R9 miss ready held low", waits, 1);
    chk((wb_cnt - wb0) == int'(ewb), "R6 write-back count", wb_cnt - wb0, ewb);
    if (ewb) begin
      chk(last_wb_addr == wba, "R7 victim address", last_wb_addr, wba);
      chk(last_wb_data == truth[wba], "R6 write-back data", last_wb_data, truth[wba]);
    end
    chk((fill_cnt - f0) == int'(efill), we ? "R5 no fetch on write" : "R4 fetch count",
        fill_cnt - f0, efill);
    if (!we) chk(rd == truth[a], rq, rd, truth[a]);
    if (we) begin
      truth[a] = wd;
      m_dirty[i][w] = 1;
    end else if (h < 0) m_dirty[i][w] = 0;
    m_tag[i][w] = t; m_val[i][w] = 1; m_mru[i] = w[0];
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < 2; k++) begin m_val[s][k] = 0; m_dirty[s][k] = 0; end
    for (int k = 0; k < 256; k++) truth[k] = mem_b[k];
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 256; k++) begin
      mem_b[k] = DW'(k * 37 + 5);
      truth[k] = mem_b[k];
    end
    for (int s = 0; s < SETS; s++) begin
      m_mru[s] = 0;
      for (int k = 0; k < 2; k++) begin m_val[s][k] = 0; m_dirty[s][k] = 0; m_tag[s][k] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cpu_ready == 1'b0, "R1 ready low after reset", cpu_ready, 0);
    chk(mem_req == 1'b0, "R1 mem request low after reset", mem_req, 0);

    // directed: set 0
    do_access(0, 8'h08, '0, "R4 read miss data");
    chk(last_waits > 0, "R1 first access misses", last_waits, 1);
    do_access(0, 8'h08, '0, "R2 read hit data");
    do_access(1, 8'h10, 16'hA5A5, "R5");       // invalid way 1 filled
    do_access(0, 8'h10, '0, "R5 write-miss data kept");
    do_access(0, 8'h08, '0, "R7 mru on hit");  // way0 now mru
    do_access(0, 8'h18, '0, "R6 evict dirty way1");
    do_access(1, 8'h18, 16'h1234, "R3");       // write hit
    do_access(0, 8'h20, '0, "R7 evict lru");   // evicts 0x08, clean
    do_access(0, 8'h28, '0, "R3 dirty write-hit evicted"); // evicts 0x18 dirty
    do_access(0, 8'h18, '0, "R3 write-hit data in memory");

    // R10: fill all sets, reread all as hits
    for (int s = 0; s < SETS; s++) begin
      do_access(1, {5'd6, 3'(s)}, 16'(16'hC000 + s), "R10");
      do_access(0, {5'd7, 3'(s)}, '0, "R10 fill");
    end
    for (int s = 0; s < SETS; s++) begin
      do_access(0, {5'd6, 3'(s)}, '0, "R10 set isolation");
      chk(last_waits == 0, "R10 hit after sweep", last_waits, 0);
      do_access(0, {5'd7, 3'(s)}, '0, "R10 set isolation");
    end

    // R8: flush discards dirty data
    do_access(1, 8'h33, 16'hBEEF, "R8");
    do_flush();
    do_access(0, 8'h33, '0, "R8 stale memory after flush");
    chk(last_waits > 0, "R8 miss after flush", last_waits, 1);

    // random phase
    for (int n = 0; n < 900; n++) begin
      logic [4:0] t = 5'($urandom_range(0, 3));
      logic [2:0] s = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 39) == 0) do_flush();
      do_access(1'($urandom_range(0, 1)), {t, s}, 16'($urandom), "R2 random read data");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule